// File: doc/BRIEF.md
# Secure Debug Access Controller

This block decides which debug facilities of a chip are open. A static fuse word picks one of four security levels and can also disable the JTAG controller. A lifecycle code, a 64-bit chip identifier and two stored 64-bit secrets are further static inputs. At the open level, both debug enables are asserted. At the off level and the no-debug level, both stay low. At the secure level, each enable opens only after a challenge/response exchange succeeds.

The exchange runs over a narrow word port that stands in for the JTAG data register path. A challenge command makes the block stream back the chip identifier. The host then submits a secret as a series of words, together with a selector bit. The block compares the assembled secret with the stored secret that the selector names. The comparison always takes a fixed number of cycles.

On a match, the block asks the security controller to wipe sensitive data. It grants the matching debug world only once that request has been acknowledged. On a mismatch, the block locks up until reset. The boundary-scan enable does not depend on any of this; only the JTAG disable fuse and the no-return lifecycle state turn it off.

Top module: `dbg_gate_ctrl`

## Requirements
- R1: `fuse_word[1:0]` selects the level: 0 off, 1 no-debug, 2 secure, 3 open. At levels 0 and 1 both debug enables are low. At level 3 both are high. At level 2 each enable reflects its own unlock grant.
- R2: `bscan_en` is low exactly when `fuse_word[2]` (JTAG disable) is 1 or `lc_state` equals `LC_NO_RETURN` (default 7), whatever the level and the unlock state.
- R3: Only at level 2 does a challenge (`req_valid` with `req_cmd`=0) start a response. From the cycle after it is accepted, `rsp_valid` is high for ID_W/DATA_W consecutive cycles, carrying `chip_id` least significant word first. At any other level, or while locked by a failure, no response appears.
- R4: Secret words (`req_cmd`=1) are accepted only after the identifier has been fully returned. They are assembled least significant word first. `req_sel` on the first word picks the stored secret: 0 means `oem_secret`, 1 means `tz_secret`. Words sent before a challenge are ignored.
- R5: Counting from the clock edge that accepts the last secret word, the comparison lasts exactly KEY_W/CMP_W cycles. The result appears one cycle later, whatever the secret value and wherever a mismatching bit lies.
- R6: On a match, `clr_req` rises and stays high until `clr_ack` is sampled high. The debug grant is set on that same edge and never earlier.
- R7: A matched OEM secret grants only `dbg_ns_en`, and a matched TZ secret grants only `dbg_s_en`. Both enables are high only after both secrets have been matched, with a fresh challenge for each.
- R8: Submitted secrets are ignored unless `lc_state` equals `LC_OEM_CLOSED` (default 3): no `clr_req`, no failure, no grant.
- R9: On a mismatch, `unlock_fail` goes high and stays high until reset. While it is high, challenges and secrets have no effect and `clr_req` stays low.
- R10: Reset clears both grants, the failure flag and any exchange in progress.
- R11: Nothing on the request port changes the level. At level 1, a correct challenge/response sequence leaves both enables low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fuse_word | input | 3 | Level in [1:0], JTAG disable in [2] |
| lc_state | input | LC_W | Lifecycle state code |
| chip_id | input | ID_W | Chip unique identifier |
| oem_secret | input | KEY_W | Stored secret for non-secure debug |
| tz_secret | input | KEY_W | Stored secret for secure-world debug |
| req_valid | input | 1 | Request word present |
| req_cmd | input | 1 | 0 challenge, 1 secret word |
| req_sel | input | 1 | Secret selector, taken from the first secret word |
| req_data | input | DATA_W | Secret word |
| rsp_valid | output | 1 | Identifier word present |
| rsp_data | output | DATA_W | Identifier word, zero when not valid |
| clr_req | output | 1 | Sensitive-data clear request |
| clr_ack | input | 1 | Clear acknowledge |
| dbg_ns_en | output | 1 | Non-secure debug enable |
| dbg_s_en | output | 1 | Secure-world debug enable |
| bscan_en | output | 1 | Boundary-scan enable |
| unlock_fail | output | 1 | Sticky mismatch status |

## Verification
The enables and `bscan_en` are combinational on the fuse and lifecycle inputs, so the sweep samples them one time unit after driving. Identifier word i is due in the (i+1)-th cycle after the edge that accepts the challenge. The clear request or failure flag is due in cycle KEY_W/CMP_W+1 after the edge that takes the last secret word. The bench checks that both stay low in every earlier cycle, for a match and for mismatches in the top and the bottom bit. A grant is due in the cycle right after the edge that samples the acknowledge. The bench checks it at that point, having first confirmed that the enables stay low while the request is held.

// File: rtl/dbg_gate_pkg.sv
package dbg_gate_pkg;

   localparam int FUSE_W        = 3;
   localparam int FUSE_JDIS_BIT = 2;

   typedef enum logic [1:0] {
      LVL_OFF    = 2'd0,
      LVL_NODBG  = 2'd1,
      LVL_SECURE = 2'd2,
      LVL_OPEN   = 2'd3
   } sec_lvl_t;

   typedef enum logic {
      CMD_CHAL   = 1'b0,
      CMD_SECRET = 1'b1
   } req_cmd_t;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SEND,
      ST_ARMED,
      ST_CMP,
      ST_CLEAR,
      ST_FAIL
   } unl_state_t;

endpackage

// File: rtl/dbg_word_pack.sv
module dbg_word_pack #(
   parameter int TOT_W  = 64,
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_en,
   input  logic [WORD_W-1:0] din,
   output logic [TOT_W-1:0]  dout
);
   localparam int WORDS = TOT_W / WORD_W;

   generate
      if (WORDS == 1) begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        dout <= '0;
            else if (shift_en) dout <= din;
         end
      end else begin : g_shift
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        dout <= '0;
            else if (shift_en) dout <= {din, dout[TOT_W-1:WORD_W]};
         end
      end
   endgenerate

endmodule

// File: rtl/dbg_key_cmp.sv
module dbg_key_cmp #(
   parameter int KEY_W = 64,
   parameter int CMP_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [KEY_W-1:0] key_a,
   input  logic [KEY_W-1:0] key_b,
   output logic             done,
   output logic             match
);
   localparam int CHUNKS = KEY_W / CMP_W;
   localparam int IDX_W  = (CHUNKS > 1) ? $clog2(CHUNKS) : 1;
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(CHUNKS - 1);

   logic [IDX_W-1:0] idx;
   logic             acc;
   logic [CMP_W-1:0] part_a, part_b;
   logic             part_diff, last;

   assign part_a    = key_a[idx*CMP_W +: CMP_W];
   assign part_b    = key_b[idx*CMP_W +: CMP_W];
   assign part_diff = |(part_a ^ part_b);
   assign last      = (idx == IDX_LAST);
   assign done      = run && last;
   assign match     = !(acc || part_diff);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx <= '0;
         acc <= 1'b0;
      end else if (!run) begin
         idx <= '0;
         acc <= 1'b0;
      end else begin
         acc <= acc || part_diff;
         idx <= last ? '0 : idx + 1'b1;
      end
   end

endmodule

// File: rtl/dbg_unlock_fsm.sv
module dbg_unlock_fsm
   import dbg_gate_pkg::*;
#(
   parameter int KEY_WORDS = 4,
   parameter int ID_WORDS  = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic chal_ok,
   input  logic lc_ok,
   input  logic req_valid,
   input  logic req_cmd,
   input  logic req_sel,
   input  logic cmp_done,
   input  logic cmp_match,
   input  logic clr_ack,
   output logic [((ID_WORDS > 1) ? $clog2(ID_WORDS) : 1)-1:0] id_idx,
   output logic shift_en,
   output logic cmp_run,
   output logic sel_q,
   output logic rsp_valid,
   output logic clr_req,
   output logic grant_ns,
   output logic grant_s,
   output logic fail
);
   localparam int IDX_W = (ID_WORDS > 1) ? $clog2(ID_WORDS) : 1;
   localparam int CNT_W = (KEY_WORDS > 1) ? $clog2(KEY_WORDS) : 1;
   localparam logic [IDX_W-1:0] ID_LAST = IDX_W'(ID_WORDS - 1);
   localparam logic [CNT_W-1:0] KW_LAST = CNT_W'(KEY_WORDS - 1);

   unl_state_t       st;
   logic [CNT_W-1:0] cnt;
   logic             chal_take, secret_take;

   assign chal_take   = req_valid && (req_cmd == CMD_CHAL) && chal_ok;
   assign secret_take = req_valid && (req_cmd == CMD_SECRET) && chal_ok && lc_ok;

   assign shift_en  = (st == ST_ARMED) && secret_take;
   assign cmp_run   = (st == ST_CMP);
   assign rsp_valid = (st == ST_SEND);
   assign clr_req   = (st == ST_CLEAR);
   assign fail      = (st == ST_FAIL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         id_idx   <= '0;
         cnt      <= '0;
         sel_q    <= 1'b0;
         grant_ns <= 1'b0;
         grant_s  <= 1'b0;
      end else begin
         case (st)
            ST_IDLE:
               if (chal_take) begin
                  st     <= ST_SEND;
                  id_idx <= '0;
               end
            ST_SEND:
               if (id_idx == ID_LAST) begin
                  st  <= ST_ARMED;
                  cnt <= '0;
               end else begin
                  id_idx <= id_idx + 1'b1;
               end
            ST_ARMED:
               if (secret_take) begin
                  if (cnt == '0) sel_q <= req_sel;
                  if (cnt == KW_LAST) st <= ST_CMP;
                  else                cnt <= cnt + 1'b1;
               end
            ST_CMP:
               if (cmp_done) st <= cmp_match ? ST_CLEAR : ST_FAIL;
            ST_CLEAR:
               if (clr_ack) begin
                  if (sel_q) grant_s  <= 1'b1;
                  else       grant_ns <= 1'b1;
                  st <= ST_IDLE;
               end
            ST_FAIL:
               st <= ST_FAIL;
            default:
               st <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/dbg_gate_ctrl.sv
module dbg_gate_ctrl
   import dbg_gate_pkg::*;
#(
   parameter int ID_W          = 64,
   parameter int KEY_W         = 64,
   parameter int DATA_W        = 16,
   parameter int CMP_W         = 16,
   parameter int LC_W          = 3,
   parameter int LC_OEM_CLOSED = 3,
   parameter int LC_NO_RETURN  = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [FUSE_W-1:0] fuse_word,
   input  logic [LC_W-1:0]   lc_state,
   input  logic [ID_W-1:0]   chip_id,
   input  logic [KEY_W-1:0]  oem_secret,
   input  logic [KEY_W-1:0]  tz_secret,
   input  logic              req_valid,
   input  logic              req_cmd,
   input  logic              req_sel,
   input  logic [DATA_W-1:0] req_data,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data,
   output logic              clr_req,
   input  logic              clr_ack,
   output logic              dbg_ns_en,
   output logic              dbg_s_en,
   output logic              bscan_en,
   output logic              unlock_fail
);
   localparam int KEY_WORDS = KEY_W / DATA_W;
   localparam int ID_WORDS  = ID_W / DATA_W;
   localparam int IDX_W     = (ID_WORDS > 1) ? $clog2(ID_WORDS) : 1;
   localparam logic [LC_W-1:0] LC_OK_CODE = LC_W'(LC_OEM_CLOSED);
   localparam logic [LC_W-1:0] LC_NR_CODE = LC_W'(LC_NO_RETURN);

   generate
      if (KEY_W % DATA_W != 0) begin : g_bad_key_w
         $error("KEY_W must be a multiple of DATA_W");
      end
      if (ID_W % DATA_W != 0) begin : g_bad_id_w
         $error("ID_W must be a multiple of DATA_W");
      end
      if (KEY_W % CMP_W != 0) begin : g_bad_cmp_w
         $error("KEY_W must be a multiple of CMP_W");
      end
      if (LC_OEM_CLOSED >= (1 << LC_W) || LC_NO_RETURN >= (1 << LC_W)) begin : g_bad_lc
         $error("lifecycle codes must fit in LC_W bits");
      end
      if (LC_OEM_CLOSED == LC_NO_RETURN) begin : g_same_lc
         $error("lifecycle codes must differ");
      end
   endgenerate

   sec_lvl_t         lvl;
   logic             lc_ok;
   logic [IDX_W-1:0] id_idx;
   logic             shift_en, cmp_run, cmp_done, cmp_match, sel_q;
   logic             grant_ns, grant_s;
   logic [KEY_W-1:0] rx_key, ref_key;

   assign lvl      = sec_lvl_t'(fuse_word[1:0]);
   assign lc_ok    = (lc_state == LC_OK_CODE);
   assign bscan_en = !(fuse_word[FUSE_JDIS_BIT] || (lc_state == LC_NR_CODE));
   assign ref_key  = sel_q ? tz_secret : oem_secret;
   assign rsp_data = rsp_valid ? chip_id[id_idx*DATA_W +: DATA_W] : '0;

   always_comb begin
      case (lvl)
         LVL_OPEN:   begin dbg_ns_en = 1'b1;     dbg_s_en = 1'b1;    end
         LVL_SECURE: begin dbg_ns_en = grant_ns; dbg_s_en = grant_s; end
         default:    begin dbg_ns_en = 1'b0;     dbg_s_en = 1'b0;    end
      endcase
   end

   dbg_unlock_fsm #(.KEY_WORDS(KEY_WORDS), .ID_WORDS(ID_WORDS)) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .chal_ok   (lvl == LVL_SECURE),
      .lc_ok     (lc_ok),
      .req_valid (req_valid),
      .req_cmd   (req_cmd),
      .req_sel   (req_sel),
      .cmp_done  (cmp_done),
      .cmp_match (cmp_match),
      .clr_ack   (clr_ack),
      .id_idx    (id_idx),
      .shift_en  (shift_en),
      .cmp_run   (cmp_run),
      .sel_q     (sel_q),
      .rsp_valid (rsp_valid),
      .clr_req   (clr_req),
      .grant_ns  (grant_ns),
      .grant_s   (grant_s),
      .fail      (unlock_fail)
   );

   dbg_word_pack #(.TOT_W(KEY_W), .WORD_W(DATA_W)) u_pack (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (shift_en),
      .din      (req_data),
      .dout     (rx_key)
   );

   dbg_key_cmp #(.KEY_W(KEY_W), .CMP_W(CMP_W)) u_cmp (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (cmp_run),
      .key_a (rx_key),
      .key_b (ref_key),
      .done  (cmp_done),
      .match (cmp_match)
   );

endmodule

// File: rtl/dbg_gate_chk.sv
module dbg_gate_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [2:0] fuse_word,
   input logic       rsp_valid,
   input logic       clr_req,
   input logic       clr_ack,
   input logic       dbg_ns_en,
   input logic       dbg_s_en,
   input logic       unlock_fail
);
   // R1
   locked_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fuse_word[1] == 1'b0) |-> (!dbg_ns_en && !dbg_s_en));

   // R3
   rsp_lvl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (fuse_word[1:0] == 2'd2));

   // R3
   rsp_clr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !clr_req);

   // R6
   clr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_req && !clr_ack) |=> clr_req);

   // R6
   ns_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(dbg_ns_en) && fuse_word == $past(fuse_word) && fuse_word[1:0] == 2'd2)
      |-> $past(clr_req && clr_ack));

   // R6
   s_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(dbg_s_en) && fuse_word == $past(fuse_word) && fuse_word[1:0] == 2'd2)
      |-> $past(clr_req && clr_ack));

   // R9
   fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      unlock_fail |=> unlock_fail);

   // R9
   fail_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      unlock_fail |-> (!clr_req && !rsp_valid));

endmodule

bind dbg_gate_ctrl dbg_gate_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .fuse_word   (fuse_word),
   .rsp_valid   (rsp_valid),
   .clr_req     (clr_req),
   .clr_ack     (clr_ack),
   .dbg_ns_en   (dbg_ns_en),
   .dbg_s_en    (dbg_s_en),
   .unlock_fail (unlock_fail)
);

// File: tb/dbg_gate_ctrl_test.sv
`timescale 1ns/1ps
module dbg_gate_ctrl_test;
   localparam int DW     = 16;
   localparam int NWORDS = 4;
   localparam int CHUNKS = 4;
   localparam logic [63:0] ID  = 64'h0123_4567_89AB_CDEF;
   localparam logic [63:0] OEM = 64'hA5C3_1F2E_7788_9A0B;
   localparam logic [63:0] TZ  = 64'h3C5A_D00D_4411_E2F7;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [2:0]    fuse_word = 3'd2;
   logic [2:0]    lc_state = 3'd3;
   logic          req_valid = 1'b0, req_cmd = 1'b0, req_sel = 1'b0;
   logic [DW-1:0] req_data = '0;
   logic          clr_ack = 1'b0;
   logic          rsp_valid, clr_req, dbg_ns_en, dbg_s_en, bscan_en, unlock_fail;
   logic [DW-1:0] rsp_data;
   int            n_chk = 0, n_bad = 0;

   always #5 clk = ~clk;

   dbg_gate_ctrl uut (
      .clk(clk), .rst_n(rst_n), .fuse_word(fuse_word), .lc_state(lc_state),
      .chip_id(ID), .oem_secret(OEM), .tz_secret(TZ),
      .req_valid(req_valid), .req_cmd(req_cmd), .req_sel(req_sel), .req_data(req_data),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data), .clr_req(clr_req), .clr_ack(clr_ack),
      .dbg_ns_en(dbg_ns_en), .dbg_s_en(dbg_s_en), .bscan_en(bscan_en),
      .unlock_fail(unlock_fail)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_reset(input logic [2:0] fw, input logic [2:0] lc);
      @(negedge clk);
      rst_n = 1'b0; fuse_word = fw; lc_state = lc;
      req_valid = 1'b0; clr_ack = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic challenge(input bit expect_rsp);
      @(negedge clk);
      req_valid = 1'b1; req_cmd = 1'b0;
      @(negedge clk);
      req_valid = 1'b0;
      for (int i = 0; i < NWORDS; i++) begin
         chk("R3 rsp_valid", rsp_valid, expect_rsp);
         if (expect_rsp) chk("R3 id word", rsp_data, ID[i*DW +: DW]);
         @(negedge clk);
      end
      chk("R3 rsp_valid after id", rsp_valid, 1'b0);
   endtask

   task automatic submit(input logic [63:0] key, input logic sel);
      for (int w = 0; w < NWORDS; w++) begin
         @(negedge clk);
         req_valid = 1'b1; req_cmd = 1'b1; req_sel = sel; req_data = key[w*DW +: DW];
      end
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic expect_result(input logic exp_clr, input logic exp_fail);
      for (int k = 0; k < CHUNKS; k++) begin
         chk("R5 clr_req early", clr_req, 1'b0);
         chk("R5 unlock_fail early", unlock_fail, 1'b0);
         @(negedge clk);
      end
      chk("R5 clr_req due", clr_req, exp_clr);
      chk("R5 unlock_fail due", unlock_fail, exp_fail);
   endtask

   task automatic ack_clear(input logic ns_before, input logic s_before,
                            input logic ns_after, input logic s_after);
      for (int k = 0; k < 3; k++) begin
         chk("R6 clr_req held", clr_req, 1'b1);
         chk("R6 ns before ack", dbg_ns_en, ns_before);
         chk("R6 s before ack", dbg_s_en, s_before);
         @(negedge clk);
      end
      clr_ack = 1'b1;
      @(negedge clk);
      clr_ack = 1'b0;
      chk("R6 clr_req dropped", clr_req, 1'b0);
      chk("R7 ns after ack", dbg_ns_en, ns_after);
      chk("R7 s after ack", dbg_s_en, s_after);
   endtask

   initial begin
      #2_000_000;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      do_reset(3'd2, 3'd3);
      // R10 reset state
      chk("R10 ns after reset", dbg_ns_en, 1'b0);
      chk("R10 s after reset", dbg_s_en, 1'b0);
      chk("R10 fail after reset", unlock_fail, 1'b0);
      chk("R10 clr_req after reset", clr_req, 1'b0);
      chk("R10 rsp after reset", rsp_valid, 1'b0);

      // R1 R2 static sweep over level, lifecycle and disable bit
      for (int lv = 0; lv < 4; lv++)
         for (int lc = 0; lc < 8; lc++)
            for (int jd = 0; jd < 2; jd++) begin
               @(negedge clk);
               fuse_word = {jd[0], lv[1:0]};
               lc_state  = lc[2:0];
               #1;
               chk("R1 ns by level", dbg_ns_en, (lv == 3));
               chk("R1 s by level", dbg_s_en, (lv == 3));
               chk("R2 bscan", bscan_en, !(jd == 1 || lc == 7));
            end

      // R3 R4 R5 R6 R7: OEM then TZ unlock
      do_reset(3'd2, 3'd3);
      challenge(1'b1);
      submit(OEM, 1'b0);
      expect_result(1'b1, 1'b0);
      ack_clear(1'b0, 1'b0, 1'b1, 1'b0);
      challenge(1'b1);
      submit(TZ, 1'b1);
      expect_result(1'b1, 1'b0);
      ack_clear(1'b1, 1'b0, 1'b1, 1'b1);
      // R2 bscan unaffected by unlock
      chk("R2 bscan while unlocked", bscan_en, 1'b1);

      // R10 grants cleared by reset
      do_reset(3'd2, 3'd3);
      chk("R10 ns cleared", dbg_ns_en, 1'b0);
      chk("R10 s cleared", dbg_s_en, 1'b0);

      // R7 TZ alone grants only secure debug
      challenge(1'b1);
      submit(TZ, 1'b1);
      expect_result(1'b1, 1'b0);
      ack_clear(1'b0, 1'b0, 1'b0, 1'b1);

      // R4 secret words without a challenge are ignored
      do_reset(3'd2, 3'd3);
      submit(OEM, 1'b0);
      expect_result(1'b0, 1'b0);
      chk("R4 ns stays low", dbg_ns_en, 1'b0);

      // R9 R5 mismatch in top bit, then lock
      do_reset(3'd2, 3'd3);
      challenge(1'b1);
      submit(OEM ^ (64'h1 << 63), 1'b0);
      expect_result(1'b0, 1'b1);
      challenge(1'b0);
      submit(OEM, 1'b0);
      repeat (CHUNKS + 2) @(negedge clk);
      chk("R9 fail sticky", unlock_fail, 1'b1);
      chk("R9 no clr while locked", clr_req, 1'b0);
      chk("R9 ns locked", dbg_ns_en, 1'b0);

      // R5 R4 mismatch in bottom bit, and wrong selector
      do_reset(3'd2, 3'd3);
      challenge(1'b1);
      submit(TZ ^ 64'h1, 1'b1);
      expect_result(1'b0, 1'b1);
      do_reset(3'd2, 3'd3);
      challenge(1'b1);
      submit(TZ, 1'b0);
      expect_result(1'b0, 1'b1);

      // R8 wrong lifecycle: secrets ignored
      do_reset(3'd2, 3'd1);
      challenge(1'b1);
      submit(OEM, 1'b0);
      expect_result(1'b0, 1'b0);
      chk("R8 ns stays low", dbg_ns_en, 1'b0);

      // R11 R3 no-debug level: request port cannot open anything
      do_reset(3'd1, 3'd3);
      challenge(1'b0);
      submit(OEM, 1'b0);
      expect_result(1'b0, 1'b0);
      chk("R11 ns locked", dbg_ns_en, 1'b0);
      chk("R11 s locked", dbg_s_en, 1'b0);

      // R3 off level: no response
      do_reset(3'd0, 3'd3);
      challenge(1'b0);

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule